// File: doc/BRIEF.md
# Secondary Cache Line Writeback-Invalidate Controller

This controller carries out one index-addressed writeback-invalidate on an inclusive secondary data cache. Each secondary line spans several primary-cache subblocks. A request gives only a secondary index. The controller reads that line's tag entry, which holds an address tag, a three-bit coherence state and a pointer into the primary cache. It then visits the primary locations named by that pointer, one subblock after another. For each subblock it decides whether the primary copy belongs to the line and whether that copy is newer than the secondary copy, and it collects the newest data for every beat in a small line buffer.

If the line is dirty, the buffered line goes out to memory as one beat per subblock. The write address is built from the stored tag and the index. Whether or not data was written, the controller then marks the secondary line Invalid and returns a one-cycle completion pulse. Every primary subblock that matched the line has already been invalidated by that point. The operation raises nothing on the system interface beyond the memory write beats.

The tag, data and primary arrays all answer a read one cycle after it is issued. Memory beats are held until the memory side acknowledges them.

Top module: `scwbi_ctrl`

## Requirements
- R1: While reset is asserted and just after it, req_ready is 1 and mem_wvalid, done, st_wr_en and pp_inv_en are 0.
- R2: Memory beats are issued only when the captured secondary state is Dirty Exclusive (code 2) or Dirty Shared (code 4). Invalid (0), Clean Exclusive (1) and Shared (3) produce no memory beat.
- R3: A dirty line is written as SUB_N beats in ascending order. Beat k carries address {secondary tag, index, k}, and mem_wlast is 1 only on the last beat.
- R4: Subblock k of the line is looked up at primary address {primary-index field, k}, for k from 0 to SUB_N-1.
- R5: A primary subblock matches when its valid bit is 1 and its tag equals the secondary tag. When a matching subblock is dirty, its data replaces secondary beat k in the writeback. Otherwise the secondary data is sent.
- R6: Every matching primary subblock is invalidated, whether it is dirty or clean and whatever the secondary state is. Non-matching primary entries keep their valid bit.
- R7: In every case the secondary line's state is written to Invalid (code 0) at that line's index.
- R8: done is a single-cycle pulse. On a dirty line it comes in the cycle right after the acknowledge of the last beat. req_ready stays 0 from the cycle after acceptance until done.
- R9: While mem_wvalid is 1 and mem_wack is 0, mem_wvalid, mem_waddr and mem_wdata stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation on req_idx |
| req_idx | input | IDX_W | Secondary line index |
| req_ready | output | 1 | Controller idle, request accepted |
| st_rd_en | output | 1 | Secondary tag read strobe |
| st_idx | output | IDX_W | Secondary tag index for read and write |
| st_rd_tag | input | TAG_W | Tag address bits returned one cycle after read |
| st_rd_state | input | 3 | Coherence state returned with the tag |
| st_rd_pidx | input | PIDX_W | Primary-index field returned with the tag |
| st_wr_en | output | 1 | Secondary state write strobe |
| st_wr_state | output | 3 | State value to write |
| sd_rd_en | output | 1 | Secondary data read strobe |
| sd_rd_addr | output | IDX_W+BEAT_W | Secondary data address {index, beat} |
| sd_rd_data | input | DATA_W | Secondary data, one cycle after read |
| pp_rd_en | output | 1 | Primary probe read strobe |
| pp_inv_en | output | 1 | Primary invalidate strobe |
| pp_addr | output | PIDX_W+BEAT_W | Primary location for probe or invalidate |
| pp_rsp_valid | input | 1 | Probed entry valid bit |
| pp_rsp_dirty | input | 1 | Probed entry modified bit |
| pp_rsp_tag | input | TAG_W | Probed entry tag |
| pp_rsp_data | input | DATA_W | Probed entry data |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_waddr | output | TAG_W+IDX_W+BEAT_W | Memory beat address |
| mem_wdata | output | DATA_W | Memory beat data |
| mem_wlast | output | 1 | Final beat of the line |
| mem_wack | input | 1 | Memory accepts the current beat |
| done | output | 1 | Operation complete pulse |

## Verification
The bench puts dirty primary copies on the pointed-to primary set and also places decoys on the next set over. A controller that forms the probe address wrongly would send decoy data, and one that ignores the dirty bit or the tag compare would send stale or foreign words. Clean and shared lines are paired with dirty matching primaries, so a controller that decides on writeback from primary dirtiness would issue beats it must not. Memory acknowledges are stalled so that a controller advancing without an acknowledge would skip beats or signal done early. A valid primary entry with a mismatched tag sits beside matching ones, so an over-eager invalidate would clear it.

// File: rtl/scwbi_pkg.sv
package scwbi_pkg;

  // secondary line coherence codes
  localparam logic [2:0] SC_INVALID      = 3'd0;
  localparam logic [2:0] SC_CLEAN_EXCL   = 3'd1;
  localparam logic [2:0] SC_DIRTY_EXCL   = 3'd2;
  localparam logic [2:0] SC_SHARED       = 3'd3;
  localparam logic [2:0] SC_DIRTY_SHARED = 3'd4;

  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_TAG   = 3'd1,
    C_PROBE = 3'd2,
    C_CMP   = 3'd3,
    C_WB    = 3'd4,
    C_INV   = 3'd5
  } ctl_state_e;

  function automatic logic sc_needs_wb(input logic [2:0] s);
    return (s == SC_DIRTY_EXCL) || (s == SC_DIRTY_SHARED);
  endfunction

endpackage

// File: rtl/scwbi_merge.sv
module scwbi_merge #(
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] sec_data,
  input  logic              prm_valid,
  input  logic              prm_dirty,
  input  logic [TAG_W-1:0]  prm_tag,
  input  logic [DATA_W-1:0] prm_data,
  output logic              hit,
  output logic              take_prm,
  output logic [DATA_W-1:0] beat_data
);

  always_comb begin
    hit       = prm_valid && (prm_tag == line_tag);
    take_prm  = hit && prm_dirty;
    beat_data = take_prm ? prm_data : sec_data;
  end

endmodule

// File: rtl/scwbi_linebuf.sv
module scwbi_linebuf #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_ce;
    assign ent_ce = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_ce) ent_q[g] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_sel];

endmodule

// File: rtl/scwbi_fsm.sv
module scwbi_fsm
  import scwbi_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int PIDX_W = 6,
  parameter int SUB_N  = 4,
  localparam int BEAT_W = (SUB_N > 1) ? $clog2(SUB_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [2:0]        state_in,
  input  logic [PIDX_W-1:0] pidx_in,
  input  logic              mem_wack,
  output ctl_state_e        ctl_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [PIDX_W-1:0] pidx_o,
  output logic              wb_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SUB_N - 1);

  ctl_state_e        ctl_q, ctl_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [2:0]        lst_q;
  logic              idx_ce, meta_ce;

  always_comb begin
    ctl_d   = ctl_q;
    beat_d  = beat_q;
    idx_ce  = 1'b0;
    meta_ce = 1'b0;
    unique case (ctl_q)
      C_IDLE: begin
        if (req_valid) begin
          idx_ce = 1'b1;
          ctl_d  = C_TAG;
        end
      end
      C_TAG: begin
        meta_ce = 1'b1;
        beat_d  = '0;
        ctl_d   = C_PROBE;
      end
      C_PROBE: ctl_d = C_CMP;
      C_CMP: begin
        if (beat_q == LAST_BEAT) begin
          beat_d = '0;
          ctl_d  = sc_needs_wb(lst_q) ? C_WB : C_INV;
        end else begin
          beat_d = beat_q + 1'b1;
          ctl_d  = C_PROBE;
        end
      end
      C_WB: begin
        if (mem_wack) begin
          if (beat_q == LAST_BEAT) begin
            beat_d = '0;
            ctl_d  = C_INV;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      C_INV:   ctl_d = C_IDLE;
      default: ctl_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= C_IDLE;
      beat_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_ce) idx_q <= req_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      pidx_q <= '0;
      lst_q  <= SC_INVALID;
    end else if (meta_ce) begin
      tag_q  <= tag_in;
      pidx_q <= pidx_in;
      lst_q  <= state_in;
    end
  end

  assign ctl_o  = ctl_q;
  assign beat_o = beat_q;
  assign idx_o  = idx_q;
  assign tag_o  = tag_q;
  assign pidx_o = pidx_q;
  assign wb_o   = sc_needs_wb(lst_q);

  // R2: writeback phase only entered for a captured dirty state
  a_r2_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == C_WB) |-> (lst_q == SC_DIRTY_EXCL || lst_q == SC_DIRTY_SHARED));

  // R4: probe beats advance by one per compare step
  a_r4_probe_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == C_CMP && beat_q != LAST_BEAT) |=> (ctl_q == C_PROBE && beat_q == $past(beat_q) + 1'b1));

endmodule

// File: rtl/scwbi_ctrl.sv
module scwbi_ctrl
  import scwbi_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int PIDX_W = 6,
  parameter int SUB_N  = 4,
  parameter int DATA_W = 32,
  localparam int BEAT_W  = (SUB_N > 1) ? $clog2(SUB_N) : 1,
  localparam int PADDR_W = PIDX_W + BEAT_W,
  localparam int SADDR_W = IDX_W + BEAT_W,
  localparam int MADDR_W = TAG_W + IDX_W + BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_idx,
  output logic               req_ready,
  output logic               st_rd_en,
  output logic [IDX_W-1:0]   st_idx,
  input  logic [TAG_W-1:0]   st_rd_tag,
  input  logic [2:0]         st_rd_state,
  input  logic [PIDX_W-1:0]  st_rd_pidx,
  output logic               st_wr_en,
  output logic [2:0]         st_wr_state,
  output logic               sd_rd_en,
  output logic [SADDR_W-1:0] sd_rd_addr,
  input  logic [DATA_W-1:0]  sd_rd_data,
  output logic               pp_rd_en,
  output logic               pp_inv_en,
  output logic [PADDR_W-1:0] pp_addr,
  input  logic               pp_rsp_valid,
  input  logic               pp_rsp_dirty,
  input  logic [TAG_W-1:0]   pp_rsp_tag,
  input  logic [DATA_W-1:0]  pp_rsp_data,
  output logic               mem_wvalid,
  output logic [MADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_wlast,
  input  logic               mem_wack,
  output logic               done
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SUB_N - 1);

  ctl_state_e        ctl;
  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  ltag;
  logic [PIDX_W-1:0] lpidx;
  logic              need_wb;
  logic              hit, take_prm;
  logic [DATA_W-1:0] merged;
  logic              in_cmp;

  scwbi_fsm #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .PIDX_W(PIDX_W),
    .SUB_N (SUB_N)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_idx  (req_idx),
    .tag_in   (st_rd_tag),
    .state_in (st_rd_state),
    .pidx_in  (st_rd_pidx),
    .mem_wack (mem_wack),
    .ctl_o    (ctl),
    .beat_o   (beat),
    .idx_o    (idx),
    .tag_o    (ltag),
    .pidx_o   (lpidx),
    .wb_o     (need_wb)
  );

  scwbi_merge #(
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_merge (
    .line_tag (ltag),
    .sec_data (sd_rd_data),
    .prm_valid(pp_rsp_valid),
    .prm_dirty(pp_rsp_dirty),
    .prm_tag  (pp_rsp_tag),
    .prm_data (pp_rsp_data),
    .hit      (hit),
    .take_prm (take_prm),
    .beat_data(merged)
  );

  assign in_cmp = (ctl == C_CMP);

  scwbi_linebuf #(
    .DEPTH (SUB_N),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (in_cmp && need_wb),
    .wr_sel (beat),
    .wr_data(merged),
    .rd_sel (beat),
    .rd_data(mem_wdata)
  );

  always_comb begin
    req_ready   = (ctl == C_IDLE);
    st_rd_en    = (ctl == C_IDLE) && req_valid;
    st_idx      = (ctl == C_IDLE) ? req_idx : idx;
    st_wr_en    = (ctl == C_INV);
    st_wr_state = SC_INVALID;
    sd_rd_en    = (ctl == C_PROBE);
    sd_rd_addr  = {idx, beat};
    pp_rd_en    = (ctl == C_PROBE);
    pp_inv_en   = in_cmp && hit;
    pp_addr     = {lpidx, beat};
    mem_wvalid  = (ctl == C_WB);
    mem_waddr   = {ltag, idx, beat};
    mem_wlast   = (ctl == C_WB) && (beat == LAST_BEAT);
    done        = (ctl == C_INV);
  end

  // R9: a beat waiting for acknowledge is held unchanged
  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wack) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: after a writeback, completion follows the final acknowledged beat
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_wvalid)) |-> $past(mem_wack && mem_wlast));

  // R6: an invalidate only follows a probe read one cycle earlier
  a_r6_inv_after_probe: assert property (@(posedge clk) disable iff (!rst_n)
    pp_inv_en |-> $past(pp_rd_en));

  // R7: the state write carries the Invalid code
  a_r7_write_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |-> (st_wr_state == SC_INVALID));

endmodule

// File: tb/sim_scwbi_ctrl.sv
module sim_scwbi_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_idx;
  logic        req_ready;
  logic        st_rd_en;
  logic [7:0]  st_idx;
  logic [19:0] st_rd_tag;
  logic [2:0]  st_rd_state;
  logic [5:0]  st_rd_pidx;
  logic        st_wr_en;
  logic [2:0]  st_wr_state;
  logic        sd_rd_en;
  logic [9:0]  sd_rd_addr;
  logic [31:0] sd_rd_data;
  logic        pp_rd_en;
  logic        pp_inv_en;
  logic [7:0]  pp_addr;
  logic        pp_rsp_valid;
  logic        pp_rsp_dirty;
  logic [19:0] pp_rsp_tag;
  logic [31:0] pp_rsp_data;
  logic        mem_wvalid;
  logic [29:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic        mem_wlast;
  logic        mem_wack;
  logic        done;

  scwbi_ctrl u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // array models
  logic [19:0] stag [256];
  logic [2:0]  sst  [256];
  logic [5:0]  spx  [256];
  logic [31:0] sdat [1024];
  logic        pv   [256];
  logic        pd   [256];
  logic [19:0] pt   [256];
  logic [31:0] pdat [256];

  logic [29:0] wl_addr [8];
  logic [31:0] wl_data [8];
  logic        wl_last [8];
  int wn, done_cnt, cyc, last_ack_cyc, done_cyc;
  bit stall_mode;
  int ackcnt;
  int checks, fails;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (st_rd_en) begin
      st_rd_tag   <= stag[st_idx];
      st_rd_state <= sst[st_idx];
      st_rd_pidx  <= spx[st_idx];
    end
    if (sd_rd_en) sd_rd_data <= sdat[sd_rd_addr];
    if (pp_rd_en) begin
      pp_rsp_valid <= pv[pp_addr];
      pp_rsp_dirty <= pd[pp_addr];
      pp_rsp_tag   <= pt[pp_addr];
      pp_rsp_data  <= pdat[pp_addr];
    end
    if (pp_inv_en) pv[pp_addr] <= 1'b0;
    if (st_wr_en) sst[st_idx] <= st_wr_state;
    if (mem_wvalid && mem_wack) begin
      if (wn < 8) begin
        wl_addr[wn] <= mem_waddr;
        wl_data[wn] <= mem_wdata;
        wl_last[wn] <= mem_wlast;
      end
      wn <= wn + 1;
      last_ack_cyc <= cyc;
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
  end

  always @(negedge clk) begin
    ackcnt <= ackcnt + 1;
    mem_wack <= stall_mode ? (ackcnt % 3 == 2) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_line(input logic [7:0] idx, input logic [19:0] t,
                          input logic [2:0] st, input logic [5:0] px,
                          input logic [31:0] base);
    stag[idx] = t;
    sst[idx]  = st;
    spx[idx]  = px;
    for (int k = 0; k < 4; k++) sdat[{idx, k[1:0]}] = base + k;
  endtask

  task automatic set_prm(input logic [7:0] a, input logic v, input logic d,
                         input logic [19:0] t, input logic [31:0] dat);
    pv[a] = v; pd[a] = d; pt[a] = t; pdat[a] = dat;
  endtask

  // runs one operation on idx and checks every outcome against the requirements
  task automatic do_case(input string name, input logic [7:0] idx, input bit stall);
    logic [19:0] t;
    logic [2:0]  st;
    logic [5:0]  px;
    logic [31:0] exp_d [4];
    bit          exp_hit [4];
    bit          pv0 [4];
    bit          dirty;
    bit          busy_bad;
    bit          seen;
    t = stag[idx]; st = sst[idx]; px = spx[idx];
    dirty = (st == 3'd2) || (st == 3'd4);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pa;
      pa = {px, k[1:0]};
      pv0[k] = pv[pa];
      exp_hit[k] = pv[pa] && (pt[pa] == t);
      exp_d[k] = (exp_hit[k] && pd[pa]) ? pdat[pa] : sdat[{idx, k[1:0]}];
    end
    @(negedge clk);
    stall_mode = stall;
    wn = 0; done_cnt = 0;
    chk(req_ready == 1'b1, "R8", {name, " ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_idx = idx;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 0; seen = 0;
    for (int n = 0; n < 300; n++) begin
      if (done) begin seen = 1; break; end
      if (req_ready) busy_bad = 1;
      @(negedge clk);
    end
    chk(seen, "R8", {name, " done seen"}, seen, 1);
    chk(!busy_bad, "R8", {name, " ready low while busy"}, busy_bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", {name, " done single cycle"}, done, 0);
    chk(done_cnt == 1, "R8", {name, " done count"}, done_cnt, 1);
    chk(wn == (dirty ? 4 : 0), "R2", {name, " beat count"}, wn, dirty ? 4 : 0);
    if (dirty && wn == 4) begin
      chk(done_cyc == last_ack_cyc + 1, "R8", {name, " done after last ack"},
          done_cyc - last_ack_cyc, 1);
      for (int k = 0; k < 4; k++) begin
        chk(wl_addr[k] == {t, idx, k[1:0]}, "R3", {name, " beat address"},
            wl_addr[k], {t, idx, k[1:0]});
        chk(wl_last[k] == (k == 3), "R3", {name, " last flag"}, wl_last[k], k == 3);
        chk(wl_data[k] == exp_d[k], "R5", {name, " beat data (R4 location)"},
            wl_data[k], exp_d[k]);
      end
    end
    chk(sst[idx] == 3'd0, "R7", {name, " secondary invalid"}, sst[idx], 0);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pa;
      pa = {px, k[1:0]};
      chk(pv[pa] == (pv0[k] && !exp_hit[k]), "R6", {name, " primary valid"},
          pv[pa], pv0[k] && !exp_hit[k]);
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(mem_wvalid == 1'b0, "R1", "reset wvalid", mem_wvalid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(st_wr_en == 1'b0 && pp_inv_en == 1'b0, "R1", "reset strobes",
        {st_wr_en, pp_inv_en}, 0);
  endtask

  task automatic t_dirty_excl_plain;
    set_line(8'h05, 20'hABCDE, 3'd2, 6'h11, 32'h1000_0000);
    do_case("dirty-excl no primary", 8'h05, 1'b0);
  endtask

  task automatic t_dirty_shared_merge;
    set_line(8'h3C, 20'h12345, 3'd4, 6'h22, 32'h2000_0000);
    set_prm({6'h22, 2'd0}, 1, 0, 20'h12345, 32'hAAAA_0000);
    set_prm({6'h22, 2'd1}, 1, 1, 20'h12345, 32'hBBBB_0001);
    set_prm({6'h22, 2'd2}, 1, 1, 20'h54321, 32'hCCCC_0002);
    set_prm({6'h22, 2'd3}, 1, 1, 20'h12345, 32'hDDDD_0003);
    for (int k = 0; k < 4; k++)
      set_prm({6'h23, k[1:0]}, 1, 1, 20'h12345, 32'hDEC0_0000 + k);
    do_case("dirty-shared merge stalled", 8'h3C, 1'b1);
    chk(pv[{6'h23, 2'd0}] == 1'b1, "R4", "decoy set untouched", pv[{6'h23, 2'd0}], 1);
  endtask

  task automatic t_clean_excl;
    set_line(8'h09, 20'h0F0F0, 3'd1, 6'h05, 32'h3000_0000);
    set_prm({6'h05, 2'd1}, 1, 1, 20'h0F0F0, 32'h5555_0001);
    set_prm({6'h05, 2'd2}, 1, 0, 20'h0F0F0, 32'h5555_0002);
    do_case("clean-excl", 8'h09, 1'b0);
  endtask

  task automatic t_shared;
    set_line(8'h40, 20'h77777, 3'd3, 6'h30, 32'h4000_0000);
    set_prm({6'h30, 2'd0}, 1, 1, 20'h77777, 32'h6666_0000);
    do_case("shared", 8'h40, 1'b0);
  endtask

  task automatic t_invalid;
    set_line(8'h41, 20'h00001, 3'd0, 6'h31, 32'h5000_0000);
    do_case("invalid", 8'h41, 1'b1);
  endtask

  task automatic t_top_index;
    set_line(8'hFF, 20'hFFFFF, 3'd4, 6'h3F, 32'hF000_0000);
    set_prm({6'h3F, 2'd3}, 1, 1, 20'hFFFFF, 32'h9999_0003);
    set_prm({6'h3F, 2'd0}, 0, 1, 20'hFFFFF, 32'h8888_0000);
    do_case("top index dirty-shared", 8'hFF, 1'b1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; wn = 0; done_cnt = 0; ackcnt = 0;
    last_ack_cyc = 0; done_cyc = 0; stall_mode = 0;
    req_valid = 0; req_idx = '0; mem_wack = 0;
    st_rd_tag = '0; st_rd_state = '0; st_rd_pidx = '0; sd_rd_data = '0;
    pp_rsp_valid = 0; pp_rsp_dirty = 0; pp_rsp_tag = '0; pp_rsp_data = '0;
    for (int i = 0; i < 256; i++) begin
      stag[i] = '0; sst[i] = '0; spx[i] = '0;
      pv[i] = 0; pd[i] = 0; pt[i] = '0; pdat[i] = '0;
    end
    for (int i = 0; i < 1024; i++) sdat[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dirty_excl_plain();
    t_dirty_shared_merge();
    t_clean_excl();
    t_shared();
    t_invalid();
    t_top_index();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule